// File: doc/BRIEF.md
# Static Segment Register Bank

This block sits on a simple processor I/O bus and drives six static LED digit positions, which cannot be read back. A write cycle presents a byte on the data bus and an I/O address, with an active-low write strobe. When the write is qualified and the address decodes to one of six consecutive ports, the byte is stored in that digit's register on the rising clock edge. The register then drives its segment pattern without interruption until the next write to the same port.

Qualification needs the strobe low and address bit 9 low in the same cycle. Address bit 8 must be high and the low three bits must select a port from 0 to 5. Digit 0 is the leftmost position and sits at I/O address 0x100. The others follow one per address up to 0x105. There is no scanning and no code conversion: the byte written is the segment pattern shown. A one-hot write-enable vector is also brought out so a system can see which digit is loaded in each cycle.

Top module: `seg_latch_bank`

## Requirements
- R1: Synchronous reset (rst high at a rising edge) clears all six digit outputs to 0x00.
- R2: With wr_n low, addr[9] low, addr[8] high and addr[2:0] = k for k in 0..5, digit k takes the value of wdata at that rising edge. Digit k is bits [8k+7:8k] of seg_out, and digit 0 is the leftmost at address 0x100.
- R3: A write with wr_n high changes no digit.
- R4: A write with addr[9] high changes no digit, whatever the other address bits are.
- R5: A write with addr[8] low, or with addr[7:3] nonzero, changes no digit.
- R6: A write with addr[2:0] equal to 6 or 7 changes no digit.
- R7: At most one digit is written per cycle. wr_en bit k is high exactly when a qualified write targets digit k, so wr_en is one-hot or zero.
- R8: Between qualified writes each digit holds its value steadily. A strobe held low for several cycles leaves the written value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | I/O write strobe, active low |
| addr | input | 10 | I/O address |
| wdata | input | 8 | Data bus byte |
| seg_out | output | 48 | Six segment bytes, digit k at [8k+7:8k] |
| wr_en | output | 6 | Per-digit write enable, one-hot or zero |

## Verification
The assertions assume every input is settled at each rising edge, so that the strobe and address give a level-sampled write. They also assume that no output is examined before the first reset. The bench drives strobe, address and data together, well away from the clock edge, and applies reset first. It holds each write for a chosen number of whole cycles. This means each cycle's qualified write is decided by one stable address.

// File: rtl/seg_latch_bank.sv
module seg_latch_bank #(
  parameter int DW = 8,
  parameter int AW = 10,
  parameter int NDIG = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_n,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [NDIG*DW-1:0] seg_out,
  output logic [NDIG-1:0]    wr_en
);
  localparam int SW = 3;

  logic           bus_open;
  logic           page_hit;
  logic [SW-1:0]  sel;
  logic [DW-1:0]  digit [NDIG];

  assign bus_open = !wr_n && !addr[9];
  assign page_hit = addr[8] && (addr[7:SW] == '0);
  assign sel      = addr[SW-1:0];

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    assign wr_en[k] = bus_open && page_hit && (sel == SW'(k));

    always_ff @(posedge clk) begin
      if (rst)
        digit[k] <= '0;
      else if (wr_en[k])
        digit[k] <= wdata;
    end

    assign seg_out[k*DW +: DW] = digit[k];

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !wr_en[k] |=> $stable(seg_out[k*DW +: DW]));
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
      wr_en[k] |=> seg_out[k*DW +: DW] == $past(wdata));
  end

  assert_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
  assert_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    wr_n |-> wr_en == '0);
  assert_a9_R4: assert property (@(posedge clk) disable iff (rst)
    addr[9] |-> wr_en == '0);
  assert_page_R5: assert property (@(posedge clk) disable iff (rst)
    (!addr[8] || addr[7:3] != '0) |-> wr_en == '0);
  assert_spare_R6: assert property (@(posedge clk) disable iff (rst)
    (addr[2:0] > 3'd5) |-> wr_en == '0);
  assert_clear_R1: assert property (@(posedge clk)
    rst |=> seg_out == '0);
endmodule

// File: tb/sim_seg_latch_bank.sv
module sim_seg_latch_bank;
  logic        clk = 0;
  logic        rst = 1;
  logic        wr_n = 1;
  logic [9:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [47:0] seg_out;
  logic [5:0]  wr_en;

  int checks = 0;
  int fails  = 0;
  logic [47:0] model = '0;

  always #2.5 clk = ~clk;

  seg_latch_bank u0 (.clk(clk), .rst(rst), .wr_n(wr_n), .addr(addr),
                     .wdata(wdata), .seg_out(seg_out), .wr_en(wr_en));

  // {wr_n, addr, data}
  localparam int NV = 16;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 10'h100, 8'h3F}, {1'b0, 10'h101, 8'h06}, {1'b0, 10'h102, 8'h5B},
    {1'b0, 10'h103, 8'h4F}, {1'b0, 10'h104, 8'h66}, {1'b0, 10'h105, 8'h6D},
    {1'b1, 10'h100, 8'hFF}, {1'b0, 10'h300, 8'hAA}, {1'b0, 10'h305, 8'hAA},
    {1'b0, 10'h000, 8'hBB}, {1'b0, 10'h108, 8'hBB}, {1'b0, 10'h1F1, 8'hBB},
    {1'b0, 10'h106, 8'hCC}, {1'b0, 10'h107, 8'hCC}, {1'b0, 10'h102, 8'h80},
    {1'b0, 10'h205, 8'hDD}
  };

  function automatic string tag(logic n, logic [9:0] a);
    if (n) return "R3";
    if (a[9]) return "R4";
    if (!a[8] || a[7:3] != 0) return "R5";
    if (a[2:0] > 5) return "R6";
    return "R2";
  endfunction

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic n, logic [9:0] a, logic [7:0] d, int cyc);
    @(negedge clk);
    wr_n = n; addr = a; wdata = d;
    repeat (cyc) @(negedge clk);
    wr_n = 1; addr = '0; wdata = '0;
  endtask

  function automatic logic [5:0] expect_en(logic n, logic [9:0] a);
    logic [5:0] e = '0;
    if (!n && !a[9] && a[8] && a[7:3] == 0 && a[2:0] < 6) e[a[2:0]] = 1'b1;
    return e;
  endfunction

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        check("R1", seg_out, '0);
        check("R7", {42'b0, wr_en}, '0);

        for (int i = 0; i < NV; i++) begin
          logic n; logic [9:0] a; logic [7:0] d; logic [5:0] e;
          {n, a, d} = VEC[i];
          e = expect_en(n, a);
          @(negedge clk);
          wr_n = n; addr = a; wdata = d;
          #1 check("R7", {42'b0, wr_en}, {42'b0, e});
          @(negedge clk);
          wr_n = 1; addr = '0; wdata = '0;
          if (e != 0) model[a[2:0]*8 +: 8] = d;
          check(tag(n, a), seg_out, model);
        end

        // held strobe: value steady across cycles
        bus_write(0, 10'h104, 8'h7F, 5);
        model[32 +: 8] = 8'h7F;
        check("R8", seg_out, model);
        repeat (4) @(negedge clk);
        check("R8", seg_out, model);

        // idle bus with data toggling
        @(negedge clk); wdata = 8'hFF; addr = 10'h101;
        repeat (3) @(negedge clk);
        check("R3", seg_out, model);
        wdata = 0; addr = 0;

        // back-to-back writes to every digit
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          wr_n = 0; addr = 10'h100 + 10'(k); wdata = 8'(8'h11 * (k + 1));
          model[k*8 +: 8] = 8'(8'h11 * (k + 1));
        end
        @(negedge clk); wr_n = 1; addr = 0;
        check("R2", seg_out, model);

        // reset mid-operation
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        model = '0;
        check("R1", seg_out, model);
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule